// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit device virtual address into a physical address. It reads the page directory and then a page table from memory. Each address space has its own directory base register. Software selects an address space by writing its 7-bit ID to a select register, then writes that space's base word. The base word carries the directory frame number and the read and write permission bits for the space.

A request arrives on a valid/ready port with an address-space ID and a read/write flag. The walker fetches the directory entry through a synchronous memory read port. If that entry links to a second-level table, the walker fetches the table entry. It then checks permissions and returns one of two results: the physical address, or a fault code together with the virtual address. Only one walk is in flight at a time.

Memory is byte addressed with 4-byte entries. The directory is indexed by address bits 31:22, the table by bits 21:12, and bits 11:0 are the offset inside a 4 KiB page.

Top module: `xlat_walker`

## Requirements
- R1: A request is accepted on a clock edge where `reqValid` and `reqReady` are both high.
  - The directory read is issued in the next cycle, at byte address base frame·4096 + VA[31:22]·4.
  - The table read is issued in the cycle its directory data returns, at directory frame·4096 + VA[21:12]·4.
  - A completed walk raises `rspValid` three cycles after acceptance.
  - Read data arrives one cycle after `memRdEn`.
- R2: On success, `rspPa` equals the table entry's frame number shifted left by 12, ORed with VA[11:0], and `rspFault` is 0.
- R3: Writing `cfgSpaceId` with `cfgSpaceWe` selects an address space. A later `cfgBaseWe` stores that space's base word: frame in bits PA_W-13:0, readable in bit 31, writable in bit 30. Each space keeps its own base.
- R4: A directory entry with bit 28 clear, including an all-zero entry, gives translation fault code 1. No table read is issued, and `rspValid` rises two cycles after acceptance.
- R5: An all-zero table entry gives translation fault code 1. On any fault, `rspPa` and `rspNonSecure` are 0.
- R6: A read needs bit 31 set in the base word, the directory entry and the table entry. A write needs bit 30 set in all three. Otherwise the result is permission fault code 2, and `rspVa` carries the faulting address.
- R7: On success, `rspNonSecure` equals bit 29 of the table entry.
- R8: From acceptance until the response is taken, `reqReady` is low and `busy` is high. A request held during that time is accepted only after the response is taken.
- R9: While `rspValid` is high and `rspReady` is low, all response fields hold.
- R10: A base write on the same edge a walk is accepted affects only later walks. The accepted walk uses the old base.
- R11: Entry bits between the frame field and bit 28 do not change the physical address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgSpaceWe | input | 1 | Load the address-space select register |
| cfgSpaceId | input | SPACE_W | Address-space ID to select |
| cfgBaseWe | input | 1 | Write the base word of the selected space |
| cfgBaseData | input | 32 | Base word: frame, readable bit 31, writable bit 30 |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Walker can accept a request |
| reqVa | input | 32 | Virtual address |
| reqWrite | input | 1 | 1 = write access, 0 = read |
| reqSpace | input | SPACE_W | Address-space ID of the request |
| rspValid | output | 1 | Response valid |
| rspReady | input | 1 | Response taken |
| rspPa | output | PA_W | Physical address, 0 on fault |
| rspFault | output | 2 | 0 ok, 1 translation fault, 2 permission fault |
| rspNonSecure | output | 1 | Non-secure attribute of the page |
| rspVa | output | 32 | Virtual address of the walk |
| busy | output | 1 | A walk is in progress |
| memRdEn | output | 1 | Table memory read strobe |
| memRdAddr | output | PA_W | Byte address of the entry read |
| memRdData | input | 32 | Entry word, valid one cycle after the strobe |

## Verification
Two functions can fall on the same edge: a base-register write and the acceptance of a walk that uses that register. The bench drives `cfgBaseWe` on the same edge as `reqValid`, with a new base that points at an empty directory. The reference model snapshots the base before applying the write, so that walk is expected to succeed and the next walk to fault. A second overlap, a request held high while a walk is busy, checks that acceptance waits for the response to be taken.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_XLATE = 2'd1,
    FLT_PERM  = 2'd2
  } fault_e;

  typedef struct packed {
    logic capture;
    logic fetchDir;
    logic takeDir;
    logic fetchTbl;
    logic takeTbl;
  } walkStrobes_t;

  localparam int ENT_RD   = 31;
  localparam int ENT_WR   = 30;
  localparam int ENT_NS   = 29;
  localparam int ENT_NEXT = 28;

endpackage

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         rspReady,
  input  logic         dirLinks,
  output walkStrobes_t strobes,
  output logic         reqReady,
  output logic         rspValid,
  output logic         busy
);

  typedef enum logic [2:0] {S_IDLE, S_DIR, S_DWAIT, S_TWAIT, S_RESP} walkState_e;
  walkState_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:  if (reqValid) stateNext = S_DIR;
      S_DIR:   stateNext = S_DWAIT;
      S_DWAIT: stateNext = dirLinks ? S_TWAIT : S_RESP;
      S_TWAIT: stateNext = S_RESP;
      S_RESP:  if (rspReady) stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobes.capture  = (state == S_IDLE) && reqValid;
    strobes.fetchDir = (state == S_DIR);
    strobes.takeDir  = (state == S_DWAIT);
    strobes.fetchTbl = (state == S_DWAIT) && dirLinks;
    strobes.takeTbl  = (state == S_TWAIT);
  end

  assign reqReady = (state == S_IDLE);
  assign rspValid = (state == S_RESP);
  assign busy     = (state != S_IDLE);

  // R4: a directory entry without the link bit ends the walk with no table read
  p_dir_fault_skips_table_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.takeDir && !dirLinks) |=> (rspValid && !strobes.fetchTbl));

  // R9: a pending response stays up until it is taken
  p_hold_rsp_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> rspValid);

  // R8: no new request is taken while a response is pending
  p_single_walk_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady);

endmodule

// File: rtl/xlat_dpath.sv
module xlat_dpath
  import xlat_pkg::*;
#(
  parameter int PA_W    = 34,
  parameter int SPACE_W = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  walkStrobes_t       strobes,
  input  logic               cfgSpaceWe,
  input  logic [SPACE_W-1:0] cfgSpaceId,
  input  logic               cfgBaseWe,
  input  logic [31:0]        cfgBaseData,
  input  logic [31:0]        reqVa,
  input  logic               reqWrite,
  input  logic [SPACE_W-1:0] reqSpace,
  output logic               memRdEn,
  output logic [PA_W-1:0]    memRdAddr,
  input  logic [31:0]        memRdData,
  output logic               dirLinks,
  output logic [PA_W-1:0]    rspPa,
  output fault_e             rspFault,
  output logic               rspNonSecure,
  output logic [31:0]        rspVa
);

  localparam int FRAME_W    = PA_W - 12;
  localparam int NUM_SPACES = 1 << SPACE_W;

  logic [FRAME_W-1:0] baseFrame [NUM_SPACES];
  logic               baseRd    [NUM_SPACES];
  logic               baseWr    [NUM_SPACES];
  logic [SPACE_W-1:0] selSpace;
  logic               unusedCfgBits;

  assign unusedCfgBits = ^cfgBaseData;

  always_ff @(posedge clk) begin
    if (!rstN)           selSpace <= '0;
    else if (cfgSpaceWe) selSpace <= cfgSpaceId;
  end

  for (genvar g = 0; g < NUM_SPACES; g++) begin : g_base
    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseFrame[g] <= '0;
        baseRd[g]    <= 1'b0;
        baseWr[g]    <= 1'b0;
      end else if (cfgBaseWe && selSpace == SPACE_W'(g)) begin
        baseFrame[g] <= cfgBaseData[FRAME_W-1:0];
        baseRd[g]    <= cfgBaseData[ENT_RD];
        baseWr[g]    <= cfgBaseData[ENT_WR];
      end
    end
  end

  logic [31:0]        vaQ;
  logic               writeQ;
  logic [FRAME_W-1:0] walkFrame;
  logic               walkRd, walkWr, dirRd, dirWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ <= '0; writeQ <= 1'b0; walkFrame <= '0;
      walkRd <= 1'b0; walkWr <= 1'b0; dirRd <= 1'b0; dirWr <= 1'b0;
    end else if (strobes.capture) begin
      vaQ       <= reqVa;
      writeQ    <= reqWrite;
      walkFrame <= baseFrame[reqSpace];
      walkRd    <= baseRd[reqSpace];
      walkWr    <= baseWr[reqSpace];
    end else if (strobes.takeDir) begin
      dirRd <= memRdData[ENT_RD];
      dirWr <= memRdData[ENT_WR];
    end
  end

  assign dirLinks  = memRdData[ENT_NEXT];
  assign memRdEn   = strobes.fetchDir || strobes.fetchTbl;
  assign memRdAddr = strobes.fetchTbl ? {memRdData[FRAME_W-1:0], vaQ[21:12], 2'b00}
                                      : {walkFrame, vaQ[31:22], 2'b00};

  logic entryZero, rdOk, wrOk;
  assign entryZero = (memRdData == 32'h0);
  assign rdOk      = walkRd && dirRd && memRdData[ENT_RD];
  assign wrOk      = walkWr && dirWr && memRdData[ENT_WR];

  always_ff @(posedge clk) begin
    if (!rstN || strobes.capture) begin
      rspPa <= '0; rspFault <= FLT_NONE; rspNonSecure <= 1'b0;
    end else if (strobes.takeDir && !dirLinks) begin
      rspFault <= FLT_XLATE;
    end else if (strobes.takeTbl) begin
      if (entryZero)                  rspFault <= FLT_XLATE;
      else if (writeQ ? !wrOk : !rdOk) rspFault <= FLT_PERM;
      else begin
        rspPa        <= {memRdData[FRAME_W-1:0], vaQ[11:0]};
        rspNonSecure <= memRdData[ENT_NS];
      end
    end
  end

  assign rspVa = vaQ;

  // R5: a faulted walk never reports a physical address
  p_fault_no_pa_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rspFault != FLT_NONE) |-> (rspPa == '0 && !rspNonSecure));

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
#(
  parameter int PA_W    = 34,
  parameter int SPACE_W = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgSpaceWe,
  input  logic [SPACE_W-1:0] cfgSpaceId,
  input  logic               cfgBaseWe,
  input  logic [31:0]        cfgBaseData,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [31:0]        reqVa,
  input  logic               reqWrite,
  input  logic [SPACE_W-1:0] reqSpace,
  output logic               rspValid,
  input  logic               rspReady,
  output logic [PA_W-1:0]    rspPa,
  output logic [1:0]         rspFault,
  output logic               rspNonSecure,
  output logic [31:0]        rspVa,
  output logic               busy,
  output logic               memRdEn,
  output logic [PA_W-1:0]    memRdAddr,
  input  logic [31:0]        memRdData
);

  walkStrobes_t strobes;
  logic         dirLinks;
  fault_e       faultCode;

  xlat_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .rspReady(rspReady),
    .dirLinks(dirLinks), .strobes(strobes), .reqReady(reqReady),
    .rspValid(rspValid), .busy(busy)
  );

  xlat_dpath #(.PA_W(PA_W), .SPACE_W(SPACE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .cfgSpaceWe(cfgSpaceWe), .cfgSpaceId(cfgSpaceId),
    .cfgBaseWe(cfgBaseWe), .cfgBaseData(cfgBaseData),
    .reqVa(reqVa), .reqWrite(reqWrite), .reqSpace(reqSpace),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .dirLinks(dirLinks), .rspPa(rspPa), .rspFault(faultCode),
    .rspNonSecure(rspNonSecure), .rspVa(rspVa)
  );

  assign rspFault = faultCode;

  // R1: the directory read follows acceptance by one cycle
  p_dir_fetch_after_accept_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (memRdEn && busy));

  // R8: memory is only read during a walk
  p_fetch_only_when_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> busy);

endmodule

// File: tb/xlat_walker_bench.sv
module xlat_walker_bench;

  localparam int PA_W = 34;
  localparam int SW   = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic cfgSpaceWe = 0, cfgBaseWe = 0, reqValid = 0, reqWrite = 0, rspReady = 1;
  logic [SW-1:0] cfgSpaceId = '0, reqSpace = '0;
  logic [31:0] cfgBaseData = '0, reqVa = '0, memRdData = '0;
  logic reqReady, rspValid, rspNonSecure, busy, memRdEn;
  logic [PA_W-1:0] rspPa, memRdAddr;
  logic [1:0] rspFault;
  logic [31:0] rspVa;

  xlat_walker #(.PA_W(PA_W), .SPACE_W(SW)) u_xlat_walker (
    .clk(clk), .rstN(rstN), .cfgSpaceWe(cfgSpaceWe), .cfgSpaceId(cfgSpaceId),
    .cfgBaseWe(cfgBaseWe), .cfgBaseData(cfgBaseData), .reqValid(reqValid),
    .reqReady(reqReady), .reqVa(reqVa), .reqWrite(reqWrite), .reqSpace(reqSpace),
    .rspValid(rspValid), .rspReady(rspReady), .rspPa(rspPa), .rspFault(rspFault),
    .rspNonSecure(rspNonSecure), .rspVa(rspVa), .busy(busy), .memRdEn(memRdEn),
    .memRdAddr(memRdAddr), .memRdData(memRdData)
  );

  int checks = 0, fails = 0, cycles = 0;
  string curTag = "R1";
  bit checking = 0;

  logic [31:0] memWords [longint];
  function automatic logic [31:0] rdMem(longint a);
    return memWords.exists(a) ? memWords[a] : 32'h0;
  endfunction

  always @(posedge clk) if (memRdEn) memRdData <= rdMem(longint'(memRdAddr));

  // behavioural reference model
  logic [31:0] mdlBase [128];
  int mdlSel = 0, mdlLeft = 0;
  bit mdlBusy = 0;
  logic [PA_W-1:0] expPa;
  logic [1:0] expFault;
  logic expNs;
  logic [31:0] expVa;
  initial foreach (mdlBase[i]) mdlBase[i] = 32'h0;

  always @(posedge clk) begin
    if (!rstN) begin
      mdlBusy = 0; mdlLeft = 0; mdlSel = 0;
      foreach (mdlBase[i]) mdlBase[i] = 32'h0;
    end else begin
      if (!mdlBusy && reqValid) begin
        logic [31:0] b, d, t;
        bit okPerm;
        b = mdlBase[reqSpace];
        d = rdMem(longint'(b[21:0]) * 4096 + longint'(reqVa[31:22]) * 4);
        expVa = reqVa; expPa = '0; expNs = 0; expFault = 2'd0;
        mdlBusy = 1;
        if (!d[28]) begin
          expFault = 2'd1; mdlLeft = 2;
        end else begin
          mdlLeft = 3;
          t = rdMem(longint'(d[21:0]) * 4096 + longint'(reqVa[21:12]) * 4);
          okPerm = reqWrite ? (b[30] && d[30] && t[30]) : (b[31] && d[31] && t[31]);
          if (t == 32'h0) expFault = 2'd1;
          else if (!okPerm) expFault = 2'd2;
          else begin
            expPa = {t[21:0], reqVa[11:0]};
            expNs = t[29];
          end
        end
      end else if (mdlBusy) begin
        if (mdlLeft > 0) mdlLeft--;
        else if (rspReady) mdlBusy = 0;
      end
      if (cfgBaseWe) mdlBase[mdlSel] = cfgBaseData;
      if (cfgSpaceWe) mdlSel = int'(cfgSpaceId);
    end
  end

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (checking) begin
      bit er;
      er = mdlBusy && mdlLeft == 0;
      check("R8", "reqReady", reqReady, !mdlBusy);
      check("R8", "busy", busy, mdlBusy);
      check(curTag, "rspValid", rspValid, er);
      if (er && rspValid) begin
        check(curTag, "rspFault", rspFault, expFault);
        check(curTag, "rspPa", rspPa, expPa);
        check(curTag, "rspNonSecure", rspNonSecure, expNs);
        check(curTag, "rspVa", rspVa, expVa);
      end
    end
    if (cycles == 20000) begin
      fails++;
      $display("FAIL R8 watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic setBase(int id, logic [31:0] data);
    @(negedge clk); cfgSpaceWe = 1; cfgSpaceId = SW'(id);
    @(negedge clk); cfgSpaceWe = 0; cfgBaseWe = 1; cfgBaseData = data;
    @(negedge clk); cfgBaseWe = 0;
  endtask

  task automatic walk(string tag, int space, logic [31:0] va, bit wr, int hold);
    curTag = tag;
    @(negedge clk);
    reqValid = 1; reqVa = va; reqWrite = wr; reqSpace = SW'(space);
    rspReady = (hold == 0);
    @(negedge clk); reqValid = 0;
    while (!rspValid) @(negedge clk);
    repeat (hold) @(negedge clk);
    rspReady = 1;
    @(negedge clk);
  endtask

  function automatic logic [31:0] mkVa(int di, int ti, int off);
    return {10'(di), 10'(ti), 12'(off)};
  endfunction

  initial begin
    memWords[32'h0010_0004] = 32'hF000_0300;
    memWords[32'h0010_0008] = 32'hE000_0400;
    memWords[32'h0020_0004] = 32'hF000_0300;
    memWords[32'h0030_0008] = 32'hE001_2345;
    memWords[32'h0030_0010] = 32'h8000_0777;
    memWords[32'h0030_0014] = 32'hCFFA_BCDE;

    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R8", "reset reqReady", reqReady, 1);
    check("R9", "reset rspValid", rspValid, 0);
    check("R1", "reset memRdEn", memRdEn, 0);
    checking = 1;

    setBase(5, 32'hC000_0100);
    setBase(9, 32'h8000_0200);

    walk("R2", 5, mkVa(1, 2, 12'hABC), 0, 0);
    walk("R7", 5, mkVa(1, 2, 12'h004), 1, 0);
    walk("R5", 5, mkVa(1, 3, 12'h010), 0, 0);
    walk("R6", 5, mkVa(1, 4, 12'h020), 1, 0);
    walk("R7", 5, mkVa(1, 4, 12'h020), 0, 0);
    walk("R4", 5, mkVa(2, 2, 12'h000), 0, 0);
    walk("R4", 5, mkVa(3, 2, 12'h000), 1, 0);
    walk("R3", 9, mkVa(1, 2, 12'h111), 1, 0);
    walk("R3", 9, mkVa(1, 2, 12'h111), 0, 0);
    walk("R11", 5, mkVa(1, 5, 12'hFFF), 1, 0);
    walk("R9", 5, mkVa(1, 2, 12'h123), 0, 5);
    walk("R1", 7, mkVa(0, 0, 12'h000), 0, 0);

    // R10: base write on the same edge as acceptance
    curTag = "R10";
    @(negedge clk); cfgSpaceWe = 1; cfgSpaceId = SW'(5);
    @(negedge clk); cfgSpaceWe = 0; cfgBaseWe = 1; cfgBaseData = 32'hC000_0500;
    reqValid = 1; reqVa = mkVa(1, 2, 12'h055); reqWrite = 0; reqSpace = SW'(5);
    @(negedge clk); cfgBaseWe = 0; reqValid = 0;
    while (!rspValid) @(negedge clk);
    @(negedge clk);
    walk("R10", 5, mkVa(1, 2, 12'h055), 0, 0);
    setBase(5, 32'hC000_0100);

    // R8: request held high during a walk waits for the response
    curTag = "R8";
    @(negedge clk);
    reqValid = 1; reqVa = mkVa(1, 2, 12'h001); reqWrite = 0; reqSpace = SW'(5);
    @(negedge clk); reqVa = mkVa(1, 4, 12'h002); reqWrite = 1;
    while (!rspValid) @(negedge clk);
    @(negedge clk);
    @(negedge clk); reqValid = 0;
    while (!rspValid) @(negedge clk);
    @(negedge clk);
    repeat (4) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule